// File: doc/BRIEF.md
# Dual-Convention Host Bus Adapter

This block sits between an external microprocessor bus and the register file of a chip. It accepts either of the two common strobe conventions: a pair of separate active-low write and read strobes, or a direction line with a single data strobe. It handles a data path that is 8 or 16 bits wide. The address comes either on dedicated pins or on the low data lines, where an address-latch pulse captures it. Each bus transfer becomes exactly one single-cycle write or read pulse on a synchronous register port. The register file answers that port with 16-bit data.

The bus pins are asynchronous to the master clock. They pass through a shared synchronizer so that strobes, address and data stay aligned with each other. Static strap inputs select the conventions: the strobe style, the data-strobe polarity, the address multiplexing, the edge of the latch pulse that captures the address, the bus width, the byte order for narrow accesses, whether a write commits when the strobe or the chip select is released, and whether a read takes its address one master clock after the strobe goes active.

Top module: `hbus_host_if`

## Requirements
- R1: After reset with an idle bus (chip select high, strobes inactive), `reg_wr`, `reg_rd` and `bus_d_oe` are all low.
- R2: With `cfg_dir_strobe` low, a low `bus_wr_dir` is the write strobe and a low `bus_rd_ds` is the read strobe. With it high, `bus_rd_ds` is the data strobe and `bus_wr_dir` gives the direction: 0 means write and 1 means read.
- R3: In direction/strobe mode, `cfg_ds_act_low` high makes the data strobe active low, and low makes it active high.
- R4: With `cfg_sep_addr` low, the address is taken from `bus_d_in[5:0]`. It is captured on the falling edge of `bus_ale` when `cfg_ale_fall` is 1, and on the rising edge when it is 0. `bus_addr` is ignored in this mode.
- R5: With `cfg_wide` high, `reg_addr[0]` is 0, `reg_be` is 2'b11, the write data is `bus_d_in` and read data is returned on all 16 lines.
- R6: With `cfg_wide` low, the lane is high when `addr[0]` XOR `cfg_swap` is 1. In that case `reg_be` is 2'b10; otherwise it is 2'b01. The write byte `bus_d_in[7:0]` appears on both lanes of `reg_wdata`. A read returns the selected register byte on `bus_d_out[7:0]`, with `bus_d_out[15:8]` at 0.
- R7: With `cfg_wr_end_cs` low, a write commits once the write strobe is released. With it high, the write commits only once chip select is released, and the strobe release alone does not commit it.
- R8: With `cfg_rd_late` low, a read uses the address present when the read strobe is first seen active. With it high, the read uses the address present one master clock later.
- R9: Each bus transfer, however long its strobe, produces exactly one `reg_wr` or one `reg_rd` pulse. The two are never high together.
- R10: `bus_d_oe` is high only while chip select and the read strobe are both active. `bus_d_out` then carries the value the register file returned for the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir_strobe | input | 1 | 0: separate write/read strobes, 1: direction plus data strobe |
| cfg_ds_act_low | input | 1 | Data strobe active low when 1 |
| cfg_sep_addr | input | 1 | 1: dedicated address pins, 0: address multiplexed on data[5:0] |
| cfg_ale_fall | input | 1 | 1: capture address on falling latch edge, 0: on rising edge |
| cfg_wide | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| cfg_swap | input | 1 | Byte order for 8-bit access |
| cfg_wr_end_cs | input | 1 | 1: write commits at chip-select release |
| cfg_rd_late | input | 1 | 1: read address taken one clock after strobe |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_dir | input | 1 | Write strobe or direction |
| bus_rd_ds | input | 1 | Read strobe or data strobe |
| bus_ale | input | 1 | Address latch pulse |
| bus_addr | input | 6 | Dedicated address pins |
| bus_d_in | input | 16 | Data (and multiplexed address) from the host |
| bus_d_out | output | 16 | Read data to the host |
| bus_d_oe | output | 1 | Output enable for the data pads |
| reg_wr | output | 1 | Single-cycle register write pulse |
| reg_rd | output | 1 | Single-cycle register read pulse |
| reg_addr | output | 6 | Register byte address |
| reg_be | output | 2 | Byte lane enables |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, valid in the `reg_rd` cycle |

## Verification
The bench builds the adapter with two synchronizer stages and a late-read delay of one clock. Those are the depths at which moving the address one clock after the read strobe separates the early and late sampling options. It steps through every strap combination that changes behaviour: both strobe conventions, both data-strobe polarities, both latch edges with junk on the dedicated address pins, wide and narrow transfers with both byte orders, and both write-commit points. A write held for forty clocks shows that a long strobe still yields a single pulse.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int HB_AW    = 6;
    localparam int HB_DW    = 16;
    localparam int HB_HALF  = HB_DW / 2;
    localparam int HB_LANES = 2;

    // static strap settings
    typedef struct packed {
        logic dir_strobe;
        logic ds_act_low;
        logic sep_addr;
        logic ale_fall;
        logic wide;
        logic swap;
        logic wr_end_cs;
        logic rd_late;
    } hb_cfg_t;

    // bundle of pins that travel through the synchronizer together
    typedef struct packed {
        logic             cs_n;
        logic             wr_dir;
        logic             rd_ds;
        logic             ale;
        logic [HB_AW-1:0] addr;
        logic [HB_DW-1:0] data;
    } hb_pins_t;

    typedef struct packed {
        logic wr;
        logic rd;
    } hb_act_t;

    typedef struct packed {
        logic                wr;
        logic                rd;
        logic [HB_AW-1:0]    addr;
        logic [HB_LANES-1:0] be;
        logic [HB_DW-1:0]    data;
    } hb_acc_t;

    function automatic hb_act_t hb_strobes(hb_cfg_t c, logic wr_dir, logic rd_ds);
        hb_act_t r;
        logic    ds;
        ds = c.ds_act_low ? !rd_ds : rd_ds;
        if (!c.dir_strobe) begin
            r.wr = !wr_dir;
            r.rd = !rd_ds;
        end else begin
            r.wr = ds && !wr_dir;
            r.rd = ds && wr_dir;
        end
        return r;
    endfunction

    function automatic logic [HB_AW-1:0] hb_map_addr(logic wide, logic [HB_AW-1:0] a);
        return wide ? {a[HB_AW-1:1], 1'b0} : a;
    endfunction

    function automatic logic [HB_LANES-1:0] hb_lanes(logic wide, logic swap, logic a0);
        if (wide)
            return 2'b11;
        return (a0 ^ swap) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [HB_DW-1:0] hb_wdata(logic wide, logic [HB_DW-1:0] d);
        return wide ? d : {d[HB_HALF-1:0], d[HB_HALF-1:0]};
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch
    import hbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ale_fall,
    input  logic             ale,
    input  logic [HB_AW-1:0] ad,
    output logic [HB_AW-1:0] addr_q
);
    logic ale_q;
    logic edge_hit;

    assign edge_hit = ale_fall ? (ale_q && !ale) : (!ale_q && ale);

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            ale_q <= ale;
            if (edge_hit)
                addr_q <= ad;
        end
    end
endmodule

// File: rtl/hbus_access.sv
module hbus_access
    import hbus_pkg::*;
#(
    parameter int RD_DELAY = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  hb_cfg_t          cfg,
    input  logic             cs,
    input  hb_act_t          act,
    input  logic [HB_AW-1:0] addr,
    input  logic [HB_DW-1:0] data,
    output hb_acc_t          req
);
    localparam int HW = RD_DELAY + 1;

    logic             wr_phase, rd_phase;
    logic             armed;
    logic             commit;
    logic             rd_fire;
    logic [HW-1:0]    hist;
    logic [HB_AW-1:0] cap_addr;
    logic [HB_DW-1:0] cap_data;
    logic [HB_AW-1:0] use_addr;

    assign wr_phase = cs && act.wr;
    assign rd_phase = cs && act.rd;
    assign commit   = armed && (cfg.wr_end_cs ? !cs : !act.wr);
    assign rd_fire  = cfg.rd_late ? (rd_phase && hist[RD_DELAY-1] && !hist[RD_DELAY])
                                  : (rd_phase && !hist[0]);
    assign use_addr = commit ? cap_addr : addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            hist     <= '0;
            cap_addr <= '0;
            cap_data <= '0;
            req      <= '0;
        end else begin
            hist  <= {hist[HW-2:0], rd_phase};
            armed <= wr_phase || (armed && !commit);
            if (wr_phase) begin
                cap_addr <= addr;
                cap_data <= data;
            end
            req.wr <= commit;
            req.rd <= rd_fire && !commit;
            if (commit || rd_fire) begin
                req.addr <= hb_map_addr(cfg.wide, use_addr);
                req.be   <= hb_lanes(cfg.wide, cfg.swap, use_addr[0]);
                req.data <= hb_wdata(cfg.wide, cap_data);
            end
        end
    end
endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if
    import hbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RD_DELAY    = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_dir_strobe,
    input  logic                cfg_ds_act_low,
    input  logic                cfg_sep_addr,
    input  logic                cfg_ale_fall,
    input  logic                cfg_wide,
    input  logic                cfg_swap,
    input  logic                cfg_wr_end_cs,
    input  logic                cfg_rd_late,
    input  logic                bus_cs_n,
    input  logic                bus_wr_dir,
    input  logic                bus_rd_ds,
    input  logic                bus_ale,
    input  logic [HB_AW-1:0]    bus_addr,
    input  logic [HB_DW-1:0]    bus_d_in,
    output logic [HB_DW-1:0]    bus_d_out,
    output logic                bus_d_oe,
    output logic                reg_wr,
    output logic                reg_rd,
    output logic [HB_AW-1:0]    reg_addr,
    output logic [HB_LANES-1:0] reg_be,
    output logic [HB_DW-1:0]    reg_wdata,
    input  logic [HB_DW-1:0]    reg_rdata
);
    localparam int PW = $bits(hb_pins_t);

    hb_cfg_t          cfg;
    hb_pins_t         pins_raw, pins_s;
    logic [PW-1:0]    pins_vec;
    hb_act_t          act_raw, act_s;
    logic [HB_AW-1:0] ale_addr, cur_addr;
    hb_acc_t          req;
    logic [HB_DW-1:0] hold;

    assign cfg = '{dir_strobe: cfg_dir_strobe, ds_act_low: cfg_ds_act_low,
                   sep_addr: cfg_sep_addr, ale_fall: cfg_ale_fall, wide: cfg_wide,
                   swap: cfg_swap, wr_end_cs: cfg_wr_end_cs, rd_late: cfg_rd_late};

    assign pins_raw = '{cs_n: bus_cs_n, wr_dir: bus_wr_dir, rd_ds: bus_rd_ds,
                        ale: bus_ale, addr: bus_addr, data: bus_d_in};

    // pad enable follows the live pins so the bus is released at once
    assign act_raw  = hb_strobes(cfg, bus_wr_dir, bus_rd_ds);
    assign bus_d_oe = !bus_cs_n && act_raw.rd;

    hbus_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_vec)
    );
    assign pins_s = hb_pins_t'(pins_vec);

    hbus_addr_latch u_ale (
        .clk      (clk),
        .rst      (rst),
        .ale_fall (cfg.ale_fall),
        .ale      (pins_s.ale),
        .ad       (pins_s.data[HB_AW-1:0]),
        .addr_q   (ale_addr)
    );

    assign cur_addr = cfg.sep_addr ? pins_s.addr : ale_addr;
    assign act_s    = hb_strobes(cfg, pins_s.wr_dir, pins_s.rd_ds);

    hbus_access #(.RD_DELAY(RD_DELAY)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg),
        .cs   (!pins_s.cs_n),
        .act  (act_s),
        .addr (cur_addr),
        .data (pins_s.data),
        .req  (req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (req.rd) begin
            if (cfg.wide)
                hold <= reg_rdata;
            else
                hold <= {{HB_HALF{1'b0}},
                         req.be[1] ? reg_rdata[HB_DW-1:HB_HALF] : reg_rdata[HB_HALF-1:0]};
        end
    end

    assign bus_d_out = hold;
    assign reg_wr    = req.wr;
    assign reg_rd    = req.rd;
    assign reg_addr  = req.addr;
    assign reg_be    = req.be;
    assign reg_wdata = req.data;
endmodule

// File: rtl/hbus_checks.sv
module hbus_checks
    import hbus_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cfg_wide,
    input logic                bus_cs_n,
    input logic                bus_d_oe,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [HB_AW-1:0]    reg_addr,
    input logic [HB_LANES-1:0] reg_be
);
    a_r9_wr_single: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    a_r9_rd_single: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    a_r10_oe_needs_cs: assert property (@(posedge clk) disable iff (rst)
        bus_d_oe |-> !bus_cs_n);

    a_r5_wide_align: assert property (@(posedge clk) disable iff (rst)
        ((reg_wr || reg_rd) && cfg_wide) |-> (reg_addr[0] == 1'b0 && reg_be == 2'b11));

    a_r6_narrow_lane: assert property (@(posedge clk) disable iff (rst)
        ((reg_wr || reg_rd) && !cfg_wide) |-> ($countones(reg_be) == 1));
endmodule

bind hbus_host_if hbus_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_wide (cfg_wide),
    .bus_cs_n (bus_cs_n),
    .bus_d_oe (bus_d_oe),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_be   (reg_be)
);

// File: tb/sim_hbus_host_if.sv
`timescale 1ns/1ps
module sim_hbus_host_if;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic cfg_dir_strobe = 0, cfg_ds_act_low = 1, cfg_sep_addr = 1, cfg_ale_fall = 1;
    logic cfg_wide = 1, cfg_swap = 0, cfg_wr_end_cs = 0, cfg_rd_late = 0;
    logic bus_cs_n = 1, bus_wr_dir = 1, bus_rd_ds = 1, bus_ale = 0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_d_in = '0;
    logic [15:0] bus_d_out;
    logic        bus_d_oe;
    logic        reg_wr, reg_rd;
    logic [5:0]  reg_addr;
    logic [1:0]  reg_be;
    logic [15:0] reg_wdata, reg_rdata;

    hbus_host_if u0 (
        .clk(clk), .rst(rst),
        .cfg_dir_strobe(cfg_dir_strobe), .cfg_ds_act_low(cfg_ds_act_low),
        .cfg_sep_addr(cfg_sep_addr), .cfg_ale_fall(cfg_ale_fall),
        .cfg_wide(cfg_wide), .cfg_swap(cfg_swap),
        .cfg_wr_end_cs(cfg_wr_end_cs), .cfg_rd_late(cfg_rd_late),
        .bus_cs_n(bus_cs_n), .bus_wr_dir(bus_wr_dir), .bus_rd_ds(bus_rd_ds),
        .bus_ale(bus_ale), .bus_addr(bus_addr), .bus_d_in(bus_d_in),
        .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // register file model: distinct bytes per address
    function automatic logic [15:0] rmodel(input logic [5:0] a);
        return {~{2'b00, a}, 2'b01, a};
    endfunction
    assign reg_rdata = rmodel(reg_addr);

    int checks = 0, errors = 0;
    int wr_seen = 0, rd_seen = 0, wr_exp = 0, rd_exp = 0;
    bit done = 0;

    typedef struct {
        bit          wr;
        logic [5:0]  a;
        logic [1:0]  be;
        logic [15:0] d;
        string       tag;
    } item_t;
    item_t sb[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: pops and compares on every access pulse
    always @(negedge clk) begin
        if (!rst && (reg_wr || reg_rd)) begin
            item_t it;
            if (reg_wr) wr_seen++;
            else        rd_seen++;
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected access pulse", {reg_wr, reg_rd}, 0);
            end else begin
                it = sb.pop_front();
                chk(reg_wr == it.wr, {it.tag, " kind"}, reg_wr, it.wr);
                chk(reg_addr == it.a, {it.tag, " address"}, reg_addr, it.a);
                chk(reg_be == it.be, {it.tag, " lanes"}, reg_be, it.be);
                if (it.wr)
                    chk(reg_wdata == it.d, {it.tag, " write data"}, reg_wdata, it.d);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        finish_run();
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [5:0] ex_addr(input logic [5:0] a);
        return cfg_wide ? {a[5:1], 1'b0} : a;
    endfunction
    function automatic logic [1:0] ex_be(input logic [5:0] a);
        return cfg_wide ? 2'b11 : ((a[0] ^ cfg_swap) ? 2'b10 : 2'b01);
    endfunction
    function automatic logic [15:0] ex_rbus(input logic [5:0] a);
        logic [15:0] r;
        r = rmodel(ex_addr(a));
        if (cfg_wide) return r;
        return (a[0] ^ cfg_swap) ? {8'h00, r[15:8]} : {8'h00, r[7:0]};
    endfunction

    task automatic idle_bus();
        bus_cs_n   = 1;
        bus_wr_dir = 1;
        bus_rd_ds  = cfg_dir_strobe ? cfg_ds_act_low : 1'b1;
        bus_ale    = !cfg_ale_fall;
    endtask

    task automatic set_mode(input bit ds, input bit dsl, input bit sep, input bit af,
                            input bit wide, input bit swp, input bit wcs, input bit late);
        cfg_dir_strobe = ds; cfg_ds_act_low = dsl; cfg_sep_addr = sep; cfg_ale_fall = af;
        cfg_wide = wide; cfg_swap = swp; cfg_wr_end_cs = wcs; cfg_rd_late = late;
        idle_bus();
        step(6);
    endtask

    task automatic drive_wr(input bit on);
        if (!cfg_dir_strobe) bus_wr_dir = !on;
        else begin
            bus_wr_dir = 1'b0;
            bus_rd_ds  = cfg_ds_act_low ? !on : on;
        end
    endtask

    task automatic drive_rd(input bit on);
        if (!cfg_dir_strobe) bus_rd_ds = !on;
        else begin
            bus_wr_dir = 1'b1;
            bus_rd_ds  = cfg_ds_act_low ? !on : on;
        end
    endtask

    task automatic addr_phase(input logic [5:0] a);
        if (cfg_sep_addr) begin
            bus_addr = a;
            bus_d_in = 16'h0000;
        end else begin
            bus_addr = ~a;                  // R4: dedicated pins carry junk
            bus_d_in = {10'h155, a};
            step(3);
            bus_ale = cfg_ale_fall;
            step(3);
            bus_ale = !cfg_ale_fall;        // capturing edge
            step(3);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d, input int hold, input string tag);
        item_t it;
        int    w0;
        it.wr = 1; it.a = ex_addr(a); it.be = ex_be(a);
        it.d  = cfg_wide ? d : {d[7:0], d[7:0]};
        it.tag = tag;
        sb.push_back(it);
        wr_exp++;
        addr_phase(a);
        bus_d_in = d;
        w0 = wr_seen;
        bus_cs_n = 0;
        step(2);
        drive_wr(1);
        step(hold);
        drive_wr(0);
        step(6);
        chk(wr_seen == w0 + (cfg_wr_end_cs ? 0 : 1), "R7 commit after strobe release",
            wr_seen - w0, cfg_wr_end_cs ? 0 : 1);
        bus_cs_n = 1;
        step(6);
        chk(wr_seen == w0 + 1, "R7 commit after chip select release", wr_seen - w0, 1);
        idle_bus();
        step(3);
    endtask

    task automatic bus_read(input logic [5:0] a, input string tag);
        item_t it;
        it.wr = 0; it.a = ex_addr(a); it.be = ex_be(a); it.d = '0; it.tag = tag;
        sb.push_back(it);
        rd_exp++;
        addr_phase(a);
        bus_cs_n = 0;
        step(2);
        chk(bus_d_oe == 1'b0, "R10 no drive before read strobe", bus_d_oe, 0);
        drive_rd(1);
        step(8);
        chk(bus_d_oe == 1'b1, "R10 drive during read", bus_d_oe, 1);
        chk(bus_d_out == ex_rbus(a), {tag, " returned data"}, bus_d_out, ex_rbus(a));
        drive_rd(0);
        step(1);
        chk(bus_d_oe == 1'b0, "R10 release after read strobe", bus_d_oe, 0);
        idle_bus();
        step(4);
    endtask

    // address moves one clock after the read strobe goes active
    task automatic read_shift(input logic [5:0] a1, input logic [5:0] a2, input string tag);
        item_t it;
        it.wr = 0; it.a = ex_addr(cfg_rd_late ? a2 : a1); it.be = ex_be(cfg_rd_late ? a2 : a1);
        it.d = '0; it.tag = tag;
        sb.push_back(it);
        rd_exp++;
        bus_addr = a1;
        bus_cs_n = 0;
        step(2);
        drive_rd(1);
        step(1);
        bus_addr = a2;
        step(8);
        drive_rd(0);
        idle_bus();
        step(4);
    endtask

    initial begin
        step(5);
        rst = 0;
        step(4);
        chk(reg_wr == 0, "R1 reset write pulse", reg_wr, 0);
        chk(reg_rd == 0, "R1 reset read pulse", reg_rd, 0);
        chk(bus_d_oe == 0, "R1 reset output enable", bus_d_oe, 0);

        // separate strobes, dedicated address, 16-bit
        set_mode(0, 1, 1, 1, 1, 0, 0, 0);
        bus_write(6'h13, 16'hBEEF, 4, "R2 R5 wide write");
        bus_read(6'h0B, "R2 R5 wide read");

        // 8-bit, both byte orders
        set_mode(0, 1, 1, 1, 0, 0, 0, 0);
        bus_write(6'h05, 16'h5A3C, 4, "R6 odd byte swap0");
        bus_write(6'h04, 16'h5A71, 4, "R6 even byte swap0");
        bus_read(6'h07, "R6 odd read swap0");
        set_mode(0, 1, 1, 1, 0, 1, 0, 0);
        bus_write(6'h04, 16'hA5C3, 4, "R6 even byte swap1");
        bus_read(6'h06, "R6 even read swap1");
        bus_read(6'h09, "R6 odd read swap1");

        // direction plus data strobe, both polarities
        set_mode(1, 1, 1, 1, 1, 0, 0, 0);
        bus_write(6'h22, 16'h1234, 4, "R2 R3 dir write low strobe");
        bus_read(6'h24, "R2 R3 dir read low strobe");
        set_mode(1, 0, 1, 1, 1, 0, 0, 0);
        bus_write(6'h2A, 16'h4321, 4, "R3 dir write high strobe");
        bus_read(6'h2C, "R3 dir read high strobe");

        // multiplexed address, both latch edges
        set_mode(0, 1, 0, 1, 1, 0, 0, 0);
        bus_write(6'h36, 16'hC0DE, 4, "R4 falling latch write");
        bus_read(6'h38, "R4 falling latch read");
        set_mode(1, 1, 0, 0, 0, 1, 0, 0);
        bus_write(6'h1D, 16'h00E7, 4, "R4 rising latch write");
        bus_read(6'h1E, "R4 rising latch read");

        // commit at chip select release
        set_mode(0, 1, 1, 1, 1, 0, 1, 0);
        bus_write(6'h30, 16'hFACE, 4, "R7 cs-end write");
        set_mode(1, 1, 1, 1, 0, 0, 1, 0);
        bus_write(6'h31, 16'h0099, 4, "R7 cs-end dir write");

        // read address sampling point
        set_mode(0, 1, 1, 1, 1, 0, 0, 0);
        read_shift(6'h10, 6'h20, "R8 early sample");
        set_mode(0, 1, 1, 1, 1, 0, 0, 1);
        read_shift(6'h10, 6'h20, "R8 late sample");
        bus_read(6'h3A, "R8 late read data");

        // long strobe gives one pulse
        set_mode(0, 1, 1, 1, 1, 0, 0, 0);
        bus_write(6'h0E, 16'h7777, 40, "R9 long write");
        bus_read(6'h0C, "R9 read after long write");

        step(10);
        chk(sb.size() == 0, "R9 expected pulses left", sb.size(), 0);
        chk(wr_seen == wr_exp, "R9 write pulse count", wr_seen, wr_exp);
        chk(rd_seen == rd_exp, "R9 read pulse count", rd_seen, rd_exp);
        finish_run();
    end
endmodule